// File: doc/BRIEF.md
# SD Card SPI-Mode Command Sequencer

This block is the SPI master for one command to an SD or MMC card running in SPI mode. A host presents a 6-bit command index, a 32-bit argument and a response class, then pulses `start`. The engine lowers chip select and sends a ready byte. It then sends the framed command: the command token, the argument and a trailer byte carrying a CRC7. The CRC7 is built one bit at a time while the command bits leave the shifter.

After the frame the engine keeps clocking all-ones bytes and looks for the card's status byte. It collects any further response bytes that the response class calls for. For the busy class it keeps reading until the card stops holding the line low. It then raises chip select and pulses `done`, with the status, the extra response data and a timeout flag. Data blocks, card bring-up and DMA belong to other blocks.

Top module: `sdcmd_engine`

## Requirements
- R1: After `start` is accepted, the first byte sent on `spi_mosi` is 0xFF.
- R2: The second byte sent is binary `01` followed by the 6-bit command index, i.e. 0x40 OR index.
- R3: Bytes three to six carry the argument, most significant byte first.
- R4: The seventh byte is the CRC7 of bytes two to six, in bits 7:1, with bit 0 set to 1. The CRC7 uses generator x^7+x^3+1, a zero initial value, and input taken MSB first. For index 0 with argument 0 this byte is 0x95.
- R5: Every byte clocked after the seventh carries 0xFF on `spi_mosi`.
- R6: `rsp_status` takes the first received byte with bit 7 clear. It may follow zero up to `POLL_LIMIT` (default 8) received bytes that have bit 7 set.
- R7: If `POLL_LIMIT`+1 received bytes all have bit 7 set, the command ends with `err_timeout`=1, and no further byte is clocked.
- R8: `rsp_type` encodings: 0 = R1, 1 = R1B, 2 = R2, 3 = R3/R7. R1 reads no byte after the status. R2 reads one byte and places it in `rsp_data[7:0]`. R3/R7 read four bytes into `rsp_data`, first byte in bits 31:24. `rsp_data` is zero otherwise.
- R9: For R1B the engine reads bytes after the status until it gets a non-zero byte, which ends the command without error. If `BUSY_LIMIT` zero bytes arrive in a row, the command ends with `err_timeout`=1.
- R10: `spi_cs_n` is low from the first clock of the ready byte until the last byte of the response, and high whenever `busy` is low. The SPI link uses mode 0: `spi_sclk` idles low, and `spi_miso` is sampled on the rising edge.
- R11: `done` is a one-cycle pulse in the same cycle that `busy` falls. A `start` while `busy` is high is ignored.
- R12: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=1, and `busy`=`done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only while idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | Response class: 0 R1, 1 R1B, 2 R2, 3 R3/R7 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Last command ended on a poll or busy limit |
| rsp_status | output | 8 | Status byte of the last command |
| rsp_data | output | 32 | Extra response bytes of the last command |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to card |
| spi_cs_n | output | 1 | Active-low card select |
| spi_miso | input | 1 | Serial data from card |

## Verification
The assertions assume that `start` is a synchronous pulse, and that the command fields only matter in the cycle where they are latched. They also assume that the card changes `spi_miso` only while `spi_sclk` is low, so every sampled bit is settled. The bench drives all inputs on the falling system-clock edge. Its card model updates `spi_miso` only on falling SPI clock edges and returns 0xFF once its scripted reply runs out, so every input stays inside those assumptions.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    RSP_R1  = 2'd0,
    RSP_R1B = 2'd1,
    RSP_R2  = 2'd2,
    RSP_R37 = 2'd3
  } rsp_kind_t;

  localparam logic [6:0] CRC7_TAPS = 7'h09;  // x^3 + 1 below the x^7 term
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // one serial CRC7 step, MSB-first input
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? CRC7_TAPS : 7'h00);
  endfunction

  function automatic logic [7:0] cmd_token(input logic [5:0] idx);
    return {2'b01, idx};
  endfunction

  function automatic logic [7:0] crc_token(input logic [6:0] c);
    return {c, 1'b1};
  endfunction

  function automatic logic [2:0] extra_count(input rsp_kind_t k);
    case (k)
      RSP_R2:  return 3'd1;
      RSP_R37: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdcmd_spi_byte.sv
module sdcmd_spi_byte #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       bit_valid,
  output logic       bit_val
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active;
  logic [DW-1:0] divcnt;
  logic [2:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    rxsh;
  logic          edge_due;

  assign edge_due  = active && (divcnt == DIV_LAST);
  assign mosi      = shreg[7];
  assign bit_valid = edge_due && !sclk;   // rising edge about to happen
  assign bit_val   = shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      divcnt    <= '0;
      bitcnt    <= '0;
      sclk      <= 1'b0;
      shreg     <= 8'hFF;
      rxsh      <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          shreg  <= tx_byte;
          bitcnt <= '0;
          divcnt <= '0;
          sclk   <= 1'b0;
        end
      end else if (edge_due) begin
        divcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rxsh <= {rxsh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitcnt == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
            rx_byte   <= rxsh;
            shreg     <= 8'hFF;
          end else begin
            bitcnt <= bitcnt + 3'd1;
            shreg  <= {shreg[6:0], 1'b1};
          end
        end
      end else begin
        divcnt <= divcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic       bit_in,
  output logic [6:0] crc
);
  import sdcmd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (clear)  crc <= '0;
    else if (en)     crc <= crc7_step(crc, bit_in);
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 8,
  parameter int BUSY_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_type,
  output logic        busy,
  output logic        done,
  output logic        err_timeout,
  output logic [7:0]  rsp_status,
  output logic [31:0] rsp_data,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);
  import sdcmd_pkg::*;

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int BW = (BUSY_LIMIT > 1) ? $clog2(BUSY_LIMIT) : 1;
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT);
  localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_LIMIT - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_CMD, ST_ARG, ST_CRC, ST_POLL, ST_EXTRA, ST_BUSY
  } st_t;

  st_t         st, nst;
  logic [5:0]  idx_q;
  logic [31:0] arg_sh;
  rsp_kind_t   kind_q;
  logic [1:0]  arg_k;
  logic [PW-1:0] poll_cnt;
  logic [BW-1:0] busy_cnt;
  logic [2:0]  extra_left;

  logic        go_q;
  logic [7:0]  tx_q;
  logic        bd;
  logic [7:0]  rx;
  logic        bit_valid, bit_val;
  logic [6:0]  crc;

  // named internal events
  logic        launch, finish, fin_to;
  logic [7:0]  lbyte;
  logic        status_hit;
  logic        recv_phase;
  logic        crc_en;
  logic        accept;

  assign accept     = (st == ST_IDLE) && start;
  assign status_hit = (st == ST_POLL) && bd && !rx[7];
  assign recv_phase = (st == ST_POLL) || (st == ST_EXTRA) || (st == ST_BUSY);
  assign crc_en     = bit_valid && ((st == ST_CMD) || (st == ST_ARG));

  sdcmd_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go_q), .tx_byte(tx_q), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx), .byte_done(bd),
    .bit_valid(bit_valid), .bit_val(bit_val)
  );

  sdcmd_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(crc_en),
    .bit_in(bit_val), .crc(crc)
  );

  always_comb begin
    nst    = st;
    launch = 1'b0;
    lbyte  = FILL_BYTE;
    finish = 1'b0;
    fin_to = 1'b0;
    case (st)
      ST_IDLE: if (start) begin nst = ST_PRE; launch = 1'b1; end
      ST_PRE: if (bd) begin
        nst = ST_CMD; launch = 1'b1; lbyte = cmd_token(idx_q);
      end
      ST_CMD: if (bd) begin
        nst = ST_ARG; launch = 1'b1; lbyte = arg_sh[31:24];
      end
      ST_ARG: if (bd) begin
        launch = 1'b1;
        if (arg_k == 2'd3) begin
          nst = ST_CRC; lbyte = crc_token(crc);
        end else begin
          lbyte = arg_sh[23:16];
        end
      end
      ST_CRC: if (bd) begin nst = ST_POLL; launch = 1'b1; end
      ST_POLL: if (bd) begin
        if (!rx[7]) begin
          case (kind_q)
            RSP_R1:  finish = 1'b1;
            RSP_R1B: begin nst = ST_BUSY;  launch = 1'b1; end
            default: begin nst = ST_EXTRA; launch = 1'b1; end
          endcase
        end else if (poll_cnt == POLL_LAST) begin
          finish = 1'b1; fin_to = 1'b1;
        end else begin
          launch = 1'b1;
        end
      end
      ST_EXTRA: if (bd) begin
        if (extra_left == 3'd1) finish = 1'b1;
        else launch = 1'b1;
      end
      ST_BUSY: if (bd) begin
        if (rx != 8'h00) finish = 1'b1;
        else if (busy_cnt == BUSY_LAST) begin finish = 1'b1; fin_to = 1'b1; end
        else launch = 1'b1;
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      go_q        <= 1'b0;
      tx_q        <= FILL_BYTE;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      spi_cs_n    <= 1'b1;
      rsp_status  <= 8'hFF;
      rsp_data    <= '0;
      idx_q       <= '0;
      arg_sh      <= '0;
      kind_q      <= RSP_R1;
      arg_k       <= '0;
      poll_cnt    <= '0;
      busy_cnt    <= '0;
      extra_left  <= '0;
    end else begin
      st   <= finish ? ST_IDLE : nst;
      go_q <= launch;
      tx_q <= lbyte;
      done <= finish;
      if (accept) begin
        busy        <= 1'b1;
        spi_cs_n    <= 1'b0;
        err_timeout <= 1'b0;
        idx_q       <= cmd_idx;
        arg_sh      <= cmd_arg;
        kind_q      <= rsp_kind_t'(rsp_type);
        rsp_status  <= 8'hFF;
        rsp_data    <= '0;
        arg_k       <= '0;
      end
      if (finish) begin
        busy        <= 1'b0;
        spi_cs_n    <= 1'b1;
        err_timeout <= fin_to;
      end
      if (bd && (st == ST_ARG)) begin
        arg_k  <= arg_k + 2'd1;
        arg_sh <= {arg_sh[23:0], 8'h00};
      end
      if (bd && (st == ST_CRC)) poll_cnt <= '0;
      if (bd && (st == ST_POLL) && rx[7]) poll_cnt <= poll_cnt + 1'b1;
      if (status_hit) begin
        rsp_status <= rx;
        extra_left <= extra_count(kind_q);
        busy_cnt   <= '0;
      end
      if (bd && (st == ST_EXTRA)) begin
        rsp_data   <= {rsp_data[23:0], rx};
        extra_left <= extra_left - 3'd1;
      end
      if (bd && (st == ST_BUSY) && (rx == 8'h00)) busy_cnt <= busy_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       recv_phase,
  input logic [5:0] idx_q
);
  // R10: the SPI clock only runs with the card selected
  a_r10_clock_selected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  // R10: card deselected whenever idle
  a_r10_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R5: all ones on MOSI while the response is read
  a_r5_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_phase && spi_sclk) |-> spi_mosi);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: done coincides with busy falling
  a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11: a start while busy does not disturb the latched command
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(start)) |-> $stable(idx_q));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
  .recv_phase(recv_phase), .idx_q(idx_q)
);

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int PLIM  = 8;
  localparam int BLIM  = 4;
  localparam int FRAME = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0] rsp_type = '0;
  logic busy, done, err_timeout, spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b1;
  logic [7:0] rsp_status;
  logic [31:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_engine #(.CLK_DIV(DIV), .POLL_LIMIT(PLIM), .BUSY_LIMIT(BLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .rsp_type(rsp_type), .busy(busy), .done(done),
    .err_timeout(err_timeout), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent CRC7: polynomial long division over the 40 frame bits
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i-:8] = r[i-:8] ^ 8'h89;
    return r[6:0];
  endfunction

  // ---------------- card model ----------------
  logic [7:0] card_q[$];
  logic [7:0] seen[$];
  logic [7:0] cur = 8'hFF;
  logic [7:0] mosi_sh = 8'h00;
  int bitn = 0;
  int card_idx = 0;

  always @(negedge spi_cs_n) begin
    seen.delete();
    card_idx = 0; bitn = 0; cur = 8'hFF; spi_miso = 1'b1;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) mosi_sh = {mosi_sh[6:0], spi_mosi};
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    bitn++;
    if (bitn == 8) begin
      seen.push_back(mosi_sh);
      bitn = 0;
      card_idx++;
      if (card_idx >= FRAME && card_q.size() > 0) cur = card_q.pop_front();
      else cur = 8'hFF;
    end else begin
      cur = {cur[6:0], 1'b1};
    end
    spi_miso = cur[7];
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [55:0] frame;
    logic [7:0]  st;
    logic [31:0] data;
    bit          to;
    int          nreads;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) if (rst_n && done) begin
    if (exp_q.size() == 0) begin
      check(0, "R11", "unexpected done", 1, 0);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check(seen.size() == FRAME + e.nreads, e.req, "bytes clocked (R10 held select)",
            seen.size(), FRAME + e.nreads);
      for (int i = 0; i < FRAME && i < seen.size(); i++)
        check(seen[i] == e.frame[55-8*i -: 8], "R1 R2 R3 R4", $sformatf("frame byte %0d", i),
              seen[i], e.frame[55-8*i -: 8]);
      for (int i = FRAME; i < seen.size(); i++)
        check(seen[i] == 8'hFF, "R5", "fill byte", seen[i], 8'hFF);
      check(err_timeout == e.to, e.req, "timeout flag", err_timeout, e.to);
      if (!e.to) begin
        check(rsp_status == e.st, e.req, "status", rsp_status, e.st);
        check(rsp_data == e.data, "R8", "data", rsp_data, e.data);
      end
      check(!busy && spi_cs_n, "R11", "busy/cs at done", {busy, spi_cs_n}, 2'b01);
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                         input logic [7:0] st, input logic [31:0] data, input bit to,
                         input int nreads, input string req, input bit poke);
    exp_t e;
    logic [7:0] tok;
    tok = {2'b01, idx};
    e.frame  = {8'hFF, tok, arg, ref_crc({tok, arg}), 1'b1};
    e.st = st; e.data = data; e.to = to; e.nreads = nreads; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; rsp_type = kind; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R11: a second start mid-command with different fields must be ignored
      repeat (20) @(negedge clk);
      cmd_idx = ~idx; cmd_arg = ~arg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!done, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(spi_cs_n == 1'b1, "R12", "cs_n", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R12", "sclk", spi_sclk, 0);
    check(spi_mosi == 1'b1, "R12", "mosi", spi_mosi, 1);
    check(!busy && !done, "R12", "busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: known trailer for index 0 / argument 0
    check(ref_crc(40'h40_0000_0000) == 7'h4A, "R4", "reference crc 0x95", ref_crc(40'h4000000000), 7'h4A);

    // R1 R6: R1 after one filler
    card_q = '{8'hFF, 8'h01};
    run_cmd(6'd0, 32'h0, 2'd0, 8'h01, 32'h0, 0, 2, "R6", 0);

    // R8: R3/R7, status with no filler, four data bytes
    card_q = '{8'h01, 8'h00, 8'h00, 8'h01, 8'hAA};
    run_cmd(6'd8, 32'h0000_01AA, 2'd3, 8'h01, 32'h0000_01AA, 0, 5, "R8", 0);

    // R8: R2 second status byte
    card_q = '{8'hFF, 8'hFF, 8'h00, 8'h05};
    run_cmd(6'd13, 32'hDEAD_0000, 2'd2, 8'h00, 32'h0000_0005, 0, 4, "R8", 0);

    // R9: R1B, three busy bytes then release
    card_q = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    run_cmd(6'd12, 32'h0, 2'd1, 8'h00, 32'h0, 0, 6, "R9", 0);

    // R6 boundary: status after POLL_LIMIT fillers
    card_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h05};
    run_cmd(6'd55, 32'h1234_5678, 2'd0, 8'h05, 32'h0, 0, PLIM + 1, "R6", 0);

    // R7: no status at all
    card_q.delete();
    run_cmd(6'd17, 32'hA5A5_5A5A, 2'd0, 8'hFF, 32'h0, 1, PLIM + 1, "R7", 0);

    // R9: busy never ends, BUSY_LIMIT zero bytes
    card_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_cmd(6'd38, 32'h0000_0100, 2'd1, 8'h00, 32'h0, 1, 1 + BLIM, "R9", 0);
    card_q.delete();

    // R11: start ignored while busy; R3 with all-ones argument
    card_q = '{8'hFF, 8'h00};
    run_cmd(6'd63, 32'hFFFF_FFFF, 2'd0, 8'h00, 32'h0, 0, 2, "R11", 1);

    repeat (10) @(negedge clk);
    check(spi_cs_n && !busy, "R10", "idle after all", {spi_cs_n, busy}, 2'b10);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule